// File: doc/BRIEF.md
# Token Bucket Traffic Shaper

This block sits between a packet queue and an output interface and decides, one packet start at a time, whether the packet at the head of the queue may leave. It keeps a count of saved tokens. A free-running interval counter adds one token every configured number of clock cycles, and the count never rises above a configured capacity. A packet start moves from input to output only when at least one token is saved, and each packet that moves uses up one token.

When tokens have built up, a burst of packets can pass back to back, one per cycle, until the saved tokens are used up. After that, packets are held at the input. They are never discarded, and they wait until the next token is generated. The bucket starts full after reset, and the current token count is always visible on a status output.

Top module: `token_bucket_shaper`

## Requirements
- R1: With a configured period P (a value of 0 counts as 1), token generation events happen on every P-th cycle. The first event is in cycle P-1 after reset is released, counting the first cycle out of reset as cycle 0, and the count is one higher in the cycle after the event.
- R2: A token generated while the count is at or above the configured capacity is discarded, so the count never rises above the capacity through generation.
- R3: A transfer happens in any cycle where in_valid and out_ready are high and the count is nonzero. Without a generation event in the same cycle, the count falls by exactly one in the next cycle.
- R4: While the count is zero, out_valid and in_ready are both low, so a waiting packet is held and not lost until a token arrives.
- R5: If a generation event and a transfer fall in the same cycle, the count is unchanged in the next cycle. This also holds when the bucket is full.
- R6: out_valid equals in_valid AND (count nonzero). in_ready equals out_ready AND (count nonzero). Both are combinational in the current cycle.
- R7: While rst is high, the count loads cfg_capacity and the interval counter restarts, so the bucket is full in the first cycle after reset.
- R8: With 3 tokens saved, a period of 8 and 5 packets waiting with the output always ready, exactly 3 packets pass in the first 3 cycles, and none pass again until the token generated in cycle 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | PERIOD_W | Cycles between token generation events (0 treated as 1) |
| cfg_capacity | input | COUNT_W | Maximum number of saved tokens |
| in_valid | input | 1 | A packet start is waiting at the queue head |
| in_ready | output | 1 | The queue head is taken this cycle if valid |
| out_valid | output | 1 | A packet start is offered downstream |
| out_ready | input | 1 | Downstream accepts a packet start |
| token_count | output | COUNT_W | Current number of saved tokens |

## Verification
Assertions check on every cycle that generation at full capacity leaves the count unchanged, that a lone transfer removes exactly one token, that a simultaneous generation and transfer cancel each other, that nothing is offered on an empty bucket, and that generation events are spaced apart. Only the bench scenarios can show the absolute timing of the first and later generation events relative to reset, the load of the full bucket at reset, and the burst count of R8. For this, the bench sweeps every small capacity and period against several handshake patterns and compares each cycle to an arithmetic model.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef enum logic [1:0] {
    BKT_HOLD = 2'd0,
    BKT_ADD  = 2'd1,
    BKT_TAKE = 2'd2
  } bkt_op_e;
endpackage

// File: rtl/tbs_tick_gen.sv
module tbs_tick_gen #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] cfg_period,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] reload;

  assign reload = (cfg_period == '0) ? '0 : cfg_period - 1'b1;
  assign tick   = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= reload;
    end else if (cnt == '0) begin
      cnt <= reload;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && cfg_period > 1) |=> !tick); // R1
endmodule

// File: rtl/tbs_bucket.sv
module tbs_bucket
  import tbs_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COUNT_W-1:0] cfg_capacity,
  input  logic               tick,
  input  logic               take,
  output logic [COUNT_W-1:0] count
);
  bkt_op_e op;

  always_comb begin
    op = BKT_HOLD;
    if (tick && take) begin
      op = BKT_HOLD;
    end else if (tick && (count < cfg_capacity)) begin
      op = BKT_ADD;
    end else if (take) begin
      op = BKT_TAKE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= cfg_capacity;
    end else begin
      unique case (op)
        BKT_ADD:  count <= count + 1'b1;
        BKT_TAKE: count <= count - 1'b1;
        default:  count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (tick && !take && count >= cfg_capacity) |=> $stable(count)); // R2
  AST_TAKE_ONE: assert property (@(posedge clk) disable iff (rst)
    (take && !tick) |=> (count == $past(count) - 1'b1)); // R3
  AST_TICK_TAKE_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (take && tick) |=> $stable(count)); // R5
endmodule

// File: rtl/tbs_gate.sv
module tbs_gate #(
  parameter int COUNT_W = 8
) (
  input  logic [COUNT_W-1:0] count,
  input  logic               in_valid,
  input  logic               out_ready,
  output logic               in_ready,
  output logic               out_valid,
  output logic               take
);
  logic has_token;

  assign has_token = (count != '0);
  assign out_valid = in_valid && has_token;
  assign in_ready  = out_ready && has_token;
  assign take      = out_valid && out_ready;
endmodule

// File: rtl/token_bucket_shaper.sv
module token_bucket_shaper #(
  parameter int COUNT_W  = 8,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [COUNT_W-1:0]  cfg_capacity,
  input  logic                in_valid,
  output logic                in_ready,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [COUNT_W-1:0]  token_count
);
  logic tick;
  logic take;

  tbs_tick_gen #(.PERIOD_W(PERIOD_W)) i_tick (
    .clk        (clk),
    .rst        (rst),
    .cfg_period (cfg_period),
    .tick       (tick)
  );

  tbs_gate #(.COUNT_W(COUNT_W)) i_gate (
    .count     (token_count),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .take      (take)
  );

  tbs_bucket #(.COUNT_W(COUNT_W)) i_bucket (
    .clk          (clk),
    .rst          (rst),
    .cfg_capacity (cfg_capacity),
    .tick         (tick),
    .take         (take),
    .count        (token_count)
  );

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (token_count == '0) |-> (!out_valid && !in_ready)); // R4
  AST_PASS_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_valid); // R6
endmodule

// File: tb/test_token_bucket_shaper.sv
`timescale 1ns/1ps
module test_token_bucket_shaper;
  localparam int COUNT_W  = 8;
  localparam int PERIOD_W = 16;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [PERIOD_W-1:0] cfg_period = '0;
  logic [COUNT_W-1:0]  cfg_capacity = '0;
  logic                in_valid = 1'b0;
  logic                out_ready = 1'b0;
  logic                in_ready;
  logic                out_valid;
  logic [COUNT_W-1:0]  token_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int seen_fires;
  int lfsr = 16'hACE1;

  always #10 clk = ~clk;

  token_bucket_shaper #(.COUNT_W(COUNT_W), .PERIOD_W(PERIOD_W)) i_token_bucket_shaper (
    .clk          (clk),
    .rst          (rst),
    .cfg_period   (cfg_period),
    .cfg_capacity (cfg_capacity),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .token_count  (token_count)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Runs one configuration; the model follows the requirements cycle by cycle.
  task automatic run(input int cap, input int per, input int pat, input int ncyc);
    int eff = (per == 0) ? 1 : per;
    int mcount;
    int mcnt;
    string ctag;
    bit mtick;
    bit mfire;
    cfg_capacity = cap[COUNT_W-1:0];
    cfg_period   = per[PERIOD_W-1:0];
    in_valid  = 1'b0;
    out_ready = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mcount = cap;                      // R7 bucket full after reset
    mcnt   = eff - 1;
    ctag   = "R7";
    seen_fires = 0;
    for (int c = 0; c < ncyc; c++) begin
      check(ctag, token_count, mcount);
      case (pat)
        0: begin in_valid = 1'b1; out_ready = 1'b1; end
        1: begin in_valid = 1'b1; out_ready = (c % 3) != 0; end
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]} & 16'hFFFF;
          in_valid  = lfsr[0] | lfsr[3];
          out_ready = lfsr[1] | lfsr[5];
        end
      endcase
      #1;
      // R4 when empty, R6 otherwise
      check((mcount == 0) ? "R4" : "R6", out_valid, (in_valid && mcount != 0) ? 1 : 0);
      check((mcount == 0) ? "R4" : "R6", in_ready, (out_ready && mcount != 0) ? 1 : 0);
      if (out_valid && out_ready) seen_fires++;
      mtick = (mcnt == 0);
      mfire = in_valid && out_ready && (mcount != 0);
      if (mtick && mfire)            begin ctag = "R5"; end
      else if (mtick && mcount < cap) begin ctag = "R1"; mcount++; end
      else if (mtick)                begin ctag = "R2"; end
      else if (mfire)                begin ctag = "R3"; mcount--; end
      else                           begin ctag = "R3"; end
      mcnt = (mcnt == 0) ? eff - 1 : mcnt - 1;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    // R7 directed: reset loads capacity
    cfg_capacity = 8'd6;
    cfg_period   = 16'd3;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7", token_count, 6);
    check("R7", out_valid, 0);

    // R8 directed burst: 3 tokens, period 8, packets always waiting
    run(3, 8, 0, 8);
    check("R8", seen_fires, 3);
    run(3, 8, 0, 9);
    check("R8", seen_fires, 4);

    // Near-exhaustive sweep over small capacities, periods and patterns (R1..R7)
    for (int cap = 0; cap <= 4; cap++)
      for (int per = 0; per <= 5; per++)
        for (int pat = 0; pat <= 2; pat++)
          run(cap, per, pat, 36);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule